// File: doc/BRIEF.md
# Tile Lock Manager

The tile lock manager arbitrates exclusive ownership of shared variables among the cores of one tile. Each core can present a lock-acquire request carrying the variable's address, and the port index identifies the core. A single release input, fed through the tile's data-cache path, carries an address and the ID of the core that issued the unlock. The manager keeps a small associative table. Each entry holds a held lock, its owner, and an ordered queue of the cores waiting for it.

An acquire of a free address takes a table entry and is granted at once. An acquire of a held address puts the requester on that entry's waiter queue. A queued core gets no response until ownership reaches it, so its pipeline stays stalled. When the owner releases the lock, ownership passes to the oldest waiter. The entry is returned to the table only when no waiter remains. A release from any core other than the owner is dropped and flagged. An acquire that needs a new entry while the table is full is refused with a retry pulse.

Top module: `tile_lock_mgr`

## Requirements
- R1: After reset, `grant`, `retry` and `rel_err` are all low, `acq_ready` is low while no acquire is presented, and the table is empty.
- R2: An acquire of an address absent from the table, with a free entry available, produces a one-cycle `grant` pulse on the requester's bit in the cycle after the one in which its `acq_ready` is high. No core ever sees `grant` and `retry` together.
- R3: An acquire of an address owned by another core is accepted (`acq_ready` high) but produces neither `grant` nor `retry` for that core.
- R4: A release by the recorded owner of an entry with waiters gives a one-cycle `grant` pulse to the oldest waiter in the cycle after the release is presented. Waiters are served in arrival order.
- R5: A release by the owner of an entry with no waiters frees the entry, so a later acquire of that address by any core is granted at once. Such a release produces no grant and no error.
- R6: A release whose core is not the recorded owner, or whose address is not in the table, leaves the table unchanged and raises `rel_err` for one cycle, in the cycle after it is presented, with no grant.
- R7: When all entries (default 8) are in use, an acquire of a new address is accepted and answered by a one-cycle `retry` pulse on the requester's bit, with no grant.
- R8: In a cycle with acquire requests, exactly one requesting core sees `acq_ready` high. The search starts at the core after the last accepted one (core 0 after reset) and wraps upward by core index.
- R9: In a cycle where `rel_valid` is high, no acquire is accepted: `acq_ready` is all zero.
- R10: An acquire by the core that already owns the address is granted again at once, without queuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_valid | input | NUM_CORES | Per-core acquire request, held until accepted |
| acq_addr | input | NUM_CORES*ADDR_W | Per-core lock address; core k uses bits k*ADDR_W upward |
| acq_ready | output | NUM_CORES | Combinational acceptance, at most one bit set |
| rel_valid | input | 1 | Release message present (one per cycle) |
| rel_addr | input | ADDR_W | Address of the lock being released |
| rel_core | input | $clog2(NUM_CORES) | Core that issued the release |
| grant | output | NUM_CORES | One-cycle ownership grant per core |
| retry | output | NUM_CORES | One-cycle refusal per core, table full |
| rel_err | output | 1 | One-cycle flag for a dropped release |

## Verification
`acq_ready` is combinational, so the bench reads it 1 ns after driving on the falling edge, well before the next rising edge. `grant`, `retry` and `rel_err` all come from a single register stage. They are due exactly one cycle after the accepting edge, and the bench samples them on the next falling edge. A queued acquire's grant is due one cycle after the enabling release, so it is checked at the falling edge after that release, never at the acquire. The random phase runs one message at a time against a bench model of owners and waiter queues, so every expected vector lands on a known cycle.

// File: rtl/tlm_pkg.sv
`timescale 1ns/1ps
package tlm_pkg;
    localparam int unsigned DEF_CORES   = 4;
    localparam int unsigned DEF_ENTRIES = 8;
    localparam int unsigned DEF_ADDR_W  = 32;

    typedef enum logic [1:0] {
        ACQ_IDLE,
        ACQ_GRANT,
        ACQ_WAIT,
        ACQ_RETRY
    } acq_kind_e;
endpackage

// File: rtl/tlm_rr_arbiter.sv
`timescale 1ns/1ps
// Round-robin pick: first requester at or above ptr, wrapping.
module tlm_rr_arbiter #(
    parameter int unsigned N   = 4,
    parameter int unsigned IDW = $clog2(N)
) (
    input  logic [N-1:0]   req,
    input  logic [IDW-1:0] ptr,
    output logic [N-1:0]   gnt,
    output logic [IDW-1:0] gnt_idx,
    output logic           found
);
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int k = 0; k < int'(N); k++) begin
            int j;
            j = (int'(ptr) + k) % int'(N);
            if (!found && req[j]) begin
                found   = 1'b1;
                gnt[j]  = 1'b1;
                gnt_idx = IDW'(j);
            end
        end
    end
endmodule

// File: rtl/tlm_match.sv
`timescale 1ns/1ps
// Associative lookup of a key against the valid table entries.
module tlm_match #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned AW      = 32,
    parameter int unsigned EW      = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]    valid,
    input  logic [ENTRIES*AW-1:0] addrs,
    input  logic [AW-1:0]         key,
    output logic                  hit,
    output logic [EW-1:0]         hit_idx
);
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < int'(ENTRIES); i++) begin
            if (!hit && valid[i] && (addrs[i*AW +: AW] == key)) begin
                hit     = 1'b1;
                hit_idx = EW'(i);
            end
        end
    end
endmodule

// File: rtl/tlm_free_find.sv
`timescale 1ns/1ps
// Lowest-index unused entry.
module tlm_free_find #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned EW      = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid,
    output logic               has_free,
    output logic [EW-1:0]      free_idx
);
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = 0; i < int'(ENTRIES); i++) begin
            if (!has_free && !valid[i]) begin
                has_free = 1'b1;
                free_idx = EW'(i);
            end
        end
    end
endmodule

// File: rtl/tile_lock_mgr.sv
`timescale 1ns/1ps
module tile_lock_mgr #(
    parameter int unsigned NUM_CORES   = tlm_pkg::DEF_CORES,
    parameter int unsigned NUM_ENTRIES = tlm_pkg::DEF_ENTRIES,
    parameter int unsigned ADDR_W      = tlm_pkg::DEF_ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES-1:0]          acq_valid,
    input  logic [NUM_CORES*ADDR_W-1:0]   acq_addr,
    output logic [NUM_CORES-1:0]          acq_ready,
    input  logic                          rel_valid,
    input  logic [ADDR_W-1:0]             rel_addr,
    input  logic [$clog2(NUM_CORES)-1:0]  rel_core,
    output logic [NUM_CORES-1:0]          grant,
    output logic [NUM_CORES-1:0]          retry,
    output logic                          rel_err
);
    import tlm_pkg::*;

    localparam int unsigned ID_W  = $clog2(NUM_CORES);
    localparam int unsigned ENT_W = $clog2(NUM_ENTRIES);
    localparam int unsigned WQ_D  = NUM_CORES - 1;
    localparam int unsigned CNT_W = $clog2(WQ_D + 1);

    typedef struct packed {
        logic                      valid;
        logic [ADDR_W-1:0]         addr;
        logic [ID_W-1:0]           owner;
        logic [CNT_W-1:0]          cnt;
        logic [WQ_D-1:0][ID_W-1:0] wq;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_ENTRIES-1:0] tab;
        logic [ID_W-1:0]          ptr;
        logic [NUM_CORES-1:0]     grant;
        logic [NUM_CORES-1:0]     retry;
        logic                     err;
    } state_t;

    state_t q, d;

    logic [NUM_ENTRIES-1:0]        tab_v;
    logic [NUM_ENTRIES*ADDR_W-1:0] tab_a;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_flat
        assign tab_v[i]                   = q.tab[i].valid;
        assign tab_a[i*ADDR_W +: ADDR_W]  = q.tab[i].addr;
    end

    // Arbitration: releases take the cycle, acquires wait (R9).
    logic [NUM_CORES-1:0] arb_req;
    logic [NUM_CORES-1:0] arb_gnt;
    logic [ID_W-1:0]      arb_idx;
    logic                 arb_found;

    assign arb_req = acq_valid & {NUM_CORES{~rel_valid}};

    tlm_rr_arbiter #(.N(NUM_CORES), .IDW(ID_W)) u_arb (
        .req     (arb_req),
        .ptr     (q.ptr),
        .gnt     (arb_gnt),
        .gnt_idx (arb_idx),
        .found   (arb_found)
    );

    assign acq_ready = arb_gnt;

    logic [ADDR_W-1:0] sel_addr;
    assign sel_addr = acq_addr[arb_idx*ADDR_W +: ADDR_W];

    logic             acq_hit, rel_hit, has_free;
    logic [ENT_W-1:0] acq_idx, rel_idx, free_idx;

    tlm_match #(.ENTRIES(NUM_ENTRIES), .AW(ADDR_W), .EW(ENT_W)) u_acq_match (
        .valid (tab_v), .addrs (tab_a), .key (sel_addr),
        .hit   (acq_hit), .hit_idx (acq_idx)
    );

    tlm_match #(.ENTRIES(NUM_ENTRIES), .AW(ADDR_W), .EW(ENT_W)) u_rel_match (
        .valid (tab_v), .addrs (tab_a), .key (rel_addr),
        .hit   (rel_hit), .hit_idx (rel_idx)
    );

    tlm_free_find #(.ENTRIES(NUM_ENTRIES), .EW(ENT_W)) u_free (
        .valid (tab_v), .has_free (has_free), .free_idx (free_idx)
    );

    acq_kind_e kind;

    always_comb begin
        d       = q;
        d.grant = '0;
        d.retry = '0;
        d.err   = 1'b0;

        // Classify the accepted acquire.
        kind = ACQ_IDLE;
        if (arb_found) begin
            if (acq_hit) begin
                if (q.tab[acq_idx].owner == arb_idx)
                    kind = ACQ_GRANT;
                else if (q.tab[acq_idx].cnt < CNT_W'(WQ_D))
                    kind = ACQ_WAIT;
                else
                    kind = ACQ_RETRY;
            end else begin
                kind = has_free ? ACQ_GRANT : ACQ_RETRY;
            end
        end

        // Release handling: hand to oldest waiter or free the entry.
        if (rel_valid) begin
            if (rel_hit && (q.tab[rel_idx].owner == rel_core)) begin
                if (q.tab[rel_idx].cnt != '0) begin
                    d.tab[rel_idx].owner = q.tab[rel_idx].wq[0];
                    d.grant[q.tab[rel_idx].wq[0]] = 1'b1;
                    for (int k = 0; k < int'(WQ_D) - 1; k++)
                        d.tab[rel_idx].wq[k] = q.tab[rel_idx].wq[k+1];
                    d.tab[rel_idx].wq[WQ_D-1] = '0;
                    d.tab[rel_idx].cnt = q.tab[rel_idx].cnt - CNT_W'(1);
                end else begin
                    d.tab[rel_idx] = '0;
                end
            end else begin
                d.err = 1'b1;
            end
        end

        case (kind)
            ACQ_GRANT: begin
                if (!acq_hit) begin
                    d.tab[free_idx].valid = 1'b1;
                    d.tab[free_idx].addr  = sel_addr;
                    d.tab[free_idx].owner = arb_idx;
                    d.tab[free_idx].cnt   = '0;
                    d.tab[free_idx].wq    = '0;
                end
                d.grant[arb_idx] = 1'b1;
            end
            ACQ_WAIT: begin
                d.tab[acq_idx].wq[q.tab[acq_idx].cnt] = arb_idx;
                d.tab[acq_idx].cnt = q.tab[acq_idx].cnt + CNT_W'(1);
            end
            ACQ_RETRY: begin
                d.retry[arb_idx] = 1'b1;
            end
            default: ;
        endcase

        if (kind != ACQ_IDLE)
            d.ptr = (arb_idx == ID_W'(NUM_CORES - 1)) ? '0 : arb_idx + ID_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign grant   = q.grant;
    assign retry   = q.retry;
    assign rel_err = q.err;
endmodule

// File: rtl/tile_lock_mgr_chk.sv
`timescale 1ns/1ps
module tile_lock_mgr_chk #(
    parameter int unsigned NUM_CORES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CORES-1:0] acq_valid,
    input logic [NUM_CORES-1:0] acq_ready,
    input logic                 rel_valid,
    input logic [NUM_CORES-1:0] grant,
    input logic [NUM_CORES-1:0] retry,
    input logic                 rel_err
);
    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acq_ready)); // R8
    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_ready & ~acq_valid) == '0); // R8
    AST_RELEASE_BLOCKS_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (acq_ready == '0)); // R9
    AST_RETRY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (retry != '0) |-> ((retry & ~$past(acq_ready)) == '0)); // R7
    AST_ERR_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |-> $past(rel_valid)); // R6
    AST_ERR_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |-> (grant == '0)); // R6
    AST_GRANT_RETRY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & retry) == '0); // R2
endmodule

bind tile_lock_mgr tile_lock_mgr_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_valid (acq_valid),
    .acq_ready (acq_ready),
    .rel_valid (rel_valid),
    .grant     (grant),
    .retry     (retry),
    .rel_err   (rel_err)
);

// File: tb/tile_lock_mgr_test.sv
`timescale 1ns/1ps
module tile_lock_mgr_test;
    localparam int NC = 4;
    localparam int NE = 8;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC-1:0]   acq_valid = '0;
    logic [NC*AW-1:0] acq_addr = '0;
    logic [NC-1:0]   acq_ready;
    logic            rel_valid = 1'b0;
    logic [AW-1:0]   rel_addr = '0;
    logic [1:0]      rel_core = '0;
    logic [NC-1:0]   grant, retry;
    logic            rel_err;

    always #2 clk = ~clk;

    tile_lock_mgr uut (
        .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .acq_addr(acq_addr),
        .acq_ready(acq_ready), .rel_valid(rel_valid), .rel_addr(rel_addr),
        .rel_core(rel_core), .grant(grant), .retry(retry), .rel_err(rel_err)
    );

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- bench reference model ----------------
    bit          m_v [NE];
    logic [31:0] m_a [NE];
    int          m_o [NE];
    int          m_q [NE][NC-1];
    int          m_n [NE];

    function automatic void m_clear();
        for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_n[i] = 0; end
    endfunction

    function automatic int m_find(input logic [31:0] a);
        for (int i = 0; i < NE; i++) if (m_v[i] && m_a[i] == a) return i;
        return -1;
    endfunction

    function automatic void m_acq(input int c, input logic [31:0] a,
                                  output logic [3:0] g, output logic [3:0] r, output bit queued);
        int e;
        g = '0; r = '0; queued = 0;
        e = m_find(a);
        if (e >= 0) begin
            if (m_o[e] == c) g[c] = 1'b1;
            else begin m_q[e][m_n[e]] = c; m_n[e]++; queued = 1; end
        end else begin
            for (int i = 0; i < NE; i++)
                if (!m_v[i] && e < 0) begin
                    e = i; m_v[i] = 1; m_a[i] = a; m_o[i] = c; m_n[i] = 0;
                end
            if (e >= 0) g[c] = 1'b1; else r[c] = 1'b1;
        end
    endfunction

    function automatic void m_rel(input int c, input logic [31:0] a,
                                  output logic [3:0] g, output bit err, output int woke);
        int e;
        g = '0; err = 0; woke = -1;
        e = m_find(a);
        if (e < 0 || m_o[e] != c) err = 1;
        else if (m_n[e] > 0) begin
            woke = m_q[e][0]; m_o[e] = woke; g[woke] = 1'b1;
            for (int k = 0; k < NC-2; k++) m_q[e][k] = m_q[e][k+1];
            m_n[e]--;
        end else m_v[e] = 0;
    endfunction

    // ---------------- drivers ----------------
    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; acq_valid = '0; rel_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_clear();
    endtask

    task automatic acq(input int c, input logic [31:0] a,
                       output logic [3:0] g, output logic [3:0] r);
        @(negedge clk);
        acq_valid[c] = 1'b1;
        acq_addr[c*AW +: AW] = a;
        #1;
        while (!acq_ready[c]) begin @(negedge clk); #1; end
        @(negedge clk);
        acq_valid[c] = 1'b0;
        g = grant; r = retry;
    endtask

    task automatic rel(input int c, input logic [31:0] a,
                       output logic [3:0] g, output logic e);
        @(negedge clk);
        rel_valid = 1'b1; rel_addr = a; rel_core = 2'(c);
        @(negedge clk);
        rel_valid = 1'b0;
        g = grant; e = rel_err;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [3:0] g, r, eg, er;
        logic       e;
        bit         eq, ee;
        int         woke;
        bit         waiting [NC];

        // R1: reset state
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(grant == 0 && retry == 0 && rel_err == 0, "R1", "outputs after reset",
              {grant, retry, 3'b0, rel_err}, 0);
        check(acq_ready == 0, "R1", "ready idle", acq_ready, 0);

        // R8 + R2: all four request together, served 0,1,2,3
        @(negedge clk);
        acq_valid = 4'b1111;
        for (int k = 0; k < NC; k++) acq_addr[k*AW +: AW] = 32'h100 + 32'(4*k);
        for (int k = 0; k < NC; k++) begin
            #1;
            check(acq_ready == 4'(1 << k), "R8", "rr order ready", acq_ready, 1 << k);
            @(negedge clk);
            acq_valid[k] = 1'b0;
            check(grant == 4'(1 << k), "R2", "grant one cycle after accept", grant, 1 << k);
        end
        @(negedge clk);
        check(grant == 0, "R2", "grant is a pulse", grant, 0);
        for (int k = 0; k < NC; k++) begin
            rel(k, 32'h100 + 32'(4*k), g, e);
            check(e == 0 && g == 0, "R5", "owner release, no waiters", {g, 3'b0, e}, 0);
        end

        // R8: pointer wrapped to core 0; cores 1 and 3 request
        @(negedge clk);
        acq_valid = 4'b1010;
        acq_addr[1*AW +: AW] = 32'h110; acq_addr[3*AW +: AW] = 32'h118;
        #1;
        check(acq_ready == 4'b0010, "R8", "rr start after wrap", acq_ready, 4'b0010);
        @(negedge clk); acq_valid[1] = 1'b0;
        check(grant == 4'b0010, "R2", "grant core1", grant, 4'b0010);
        #1;
        check(acq_ready == 4'b1000, "R8", "rr next", acq_ready, 4'b1000);
        @(negedge clk); acq_valid[3] = 1'b0;
        check(grant == 4'b1000, "R2", "grant core3", grant, 4'b1000);
        rel(1, 32'h110, g, e);
        rel(3, 32'h118, g, e);

        // R3/R4/R5/R6: queueing on one address
        acq(0, 32'h500, g, r);
        check(g == 4'b0001, "R2", "first owner", g, 4'b0001);
        acq(1, 32'h500, g, r);
        check(g == 0 && r == 0, "R3", "held lock queues core1", {g, r}, 0);
        acq(2, 32'h500, g, r);
        check(g == 0 && r == 0, "R3", "held lock queues core2", {g, r}, 0);
        rel(3, 32'h500, g, e);
        check(e == 1 && g == 0, "R6", "non-owner release flagged", {g, 3'b0, e}, 1);
        @(negedge clk);
        check(rel_err == 0, "R6", "error is a pulse", rel_err, 0);
        rel(0, 32'h500, g, e);
        check(g == 4'b0010 && e == 0, "R4", "oldest waiter core1", {g, 3'b0, e}, 8'h20);
        rel(1, 32'h500, g, e);
        check(g == 4'b0100 && e == 0, "R4", "next waiter core2", {g, 3'b0, e}, 8'h40);
        rel(2, 32'h500, g, e);
        check(g == 0 && e == 0, "R5", "last release frees", {g, 3'b0, e}, 0);
        acq(3, 32'h500, g, r);
        check(g == 4'b1000, "R5", "freed address grants", g, 4'b1000);
        rel(3, 32'h500, g, e);
        rel(2, 32'h9999, g, e);
        check(e == 1 && g == 0, "R6", "unknown address flagged", {g, 3'b0, e}, 1);

        // R7: fill the table, then overflow
        for (int i = 0; i < NE; i++) begin
            acq(i % NC, 32'h2000 + 32'(4*i), g, r);
            check(g == 4'(1 << (i % NC)), "R2", "fill grant", g, 1 << (i % NC));
        end
        acq(0, 32'h3000, g, r);
        check(r == 4'b0001 && g == 0, "R7", "full table retry", {g, r}, 8'h01);
        rel(0, 32'h2000, g, e);
        acq(0, 32'h3000, g, r);
        check(g == 4'b0001 && r == 0, "R7", "granted after space", {g, r}, 8'h10);
        // R10: owner re-acquire
        acq(1, 32'h2004, g, r);
        check(g == 4'b0010 && r == 0, "R10", "owner re-acquire", {g, r}, 8'h20);

        // R9: release blocks an acquire in the same cycle
        do_reset();
        acq(1, 32'h4000, g, r);
        @(negedge clk);
        rel_valid = 1'b1; rel_addr = 32'h4000; rel_core = 2'd1;
        acq_valid[2] = 1'b1; acq_addr[2*AW +: AW] = 32'h4100;
        #1;
        check(acq_ready == 0, "R9", "no accept during release", acq_ready, 0);
        @(negedge clk);
        rel_valid = 1'b0;
        check(rel_err == 0 && grant == 0, "R9", "release applied", {grant, 3'b0, rel_err}, 0);
        #1;
        check(acq_ready == 4'b0100, "R9", "accept after release", acq_ready, 4'b0100);
        @(negedge clk);
        acq_valid[2] = 1'b0;
        check(grant == 4'b0100, "R9", "grant after release", grant, 4'b0100);

        // Random phase against the model
        do_reset();
        void'($urandom(32'd20240611));
        for (int c = 0; c < NC; c++) waiting[c] = 0;
        for (int n = 0; n < 3000; n++) begin
            int c;
            logic [31:0] a;
            c = int'($urandom % NC);
            a = 32'h1000 + 32'(16 * ($urandom % 11));
            if (($urandom % 2) == 0 && !waiting[c]) begin
                m_acq(c, a, eg, er, eq);
                acq(c, a, g, r);
                if (eq) waiting[c] = 1;
                check(g == eg && r == er, "R2", "random acquire {g,r}", {g, r}, {eg, er});
            end else begin
                if (($urandom % 5) < 3) begin
                    int s;
                    s = int'($urandom % NE);
                    for (int i = 0; i < NE; i++)
                        if (m_v[(s + i) % NE]) begin
                            c = m_o[(s + i) % NE]; a = m_a[(s + i) % NE];
                        end
                end
                m_rel(c, a, eg, ee, woke);
                rel(c, a, g, e);
                if (woke >= 0) waiting[woke] = 0;
                check(g == eg && e == ee, "R4", "random release {g,err}",
                      {g, 3'b0, e}, {eg, 3'b0, ee});
            end
        end

        finish_run();
    end
endmodule